// File: doc/BRIEF.md
# Prioritised CPU Interrupt Resolver

This block merges software interrupt requests and external interrupt lines into one candidate priority level. It compares that level with the processor's current priority level and issues a one-cycle trap request when the candidate level is strictly higher. When it takes a trap, it also latches two values: a summary word with every request bit that contributed, and the winning level.

Software posts requests by writing a request register. Only a contiguous field of that register can be written. Software request bit `SW_LO+k` stands for level `k+1`. External lines are sampled live, and an external line at bit position `i` (inside the external range) stands for level `i`. The active external line with the highest level always wins over any software request. Evaluation is not continuous. A check strobe, or a return-from-exception event, arms a flag. The next clock evaluates the inputs once and clears the flag.

Top module: `irq_level_resolver`

## Requirements
- R1: A write to the software request register keeps only bits 4 to 18 (mask 0x7fff0). Every other bit reads back as zero on `sw_req_q`.
- R2: A write to the priority level register keeps only the low 5 bits of the write data. After reset the register holds 31.
- R3: Software request bit i (4..18) stands for level i-3. When several software bits are set, the highest one gives the software level.
- R4: External line i (20..31) stands for level i. The highest active external line sets the candidate level and overrides any software level.
- R5: The summary word is the OR of every set software request bit and every active external line in bits 20..31, each at its own bit position. External lines 0..19 have no effect on the level or the summary.
- R6: A trap is taken only when the candidate level is non-zero and strictly greater than the priority level register. An equal level does not trap.
- R7: When a trap is taken, `summary_q` and `int_id_q` update in the same cycle that `trap_o` is high. When no trap is taken, both keep their previous values.
- R8: `check_req` or `exc_return` sampled at one clock edge arms the evaluation. The next edge evaluates and disarms it, and a trap shows on `trap_o` for one cycle right after that edge. Without a new arming event there is no further trap.
- R9: After reset, `trap_o`, `summary_q`, `int_id_q` and `sw_req_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req_we | input | 1 | Write strobe for the software request register |
| sw_req_wdata | input | 32 | Software request write data |
| ext_irq | input | 32 | Live external interrupt status lines |
| ipl_we | input | 1 | Write strobe for the priority level register |
| ipl_wdata | input | 8 | Priority level write data |
| check_req | input | 1 | Arms one evaluation |
| exc_return | input | 1 | Return-from-exception event, also arms one evaluation |
| trap_o | output | 1 | One-cycle trap request |
| sw_req_q | output | 32 | Software request register |
| ipl_q | output | 5 | Current priority level register |
| summary_q | output | 32 | Latched summary of contributing request bits |
| int_id_q | output | 5 | Latched winning level |

## Verification
The bench checks single software bits and pairs of software bits to show the highest-bit priority and the remapping of bit positions to levels. It mixes software bits with external lines to confirm that external lines override and that the summary combines both sources. It sets the candidate level equal to the priority level, and then one below it, to separate a strict compare from a non-strict one. Low external lines, an empty request set, an arming by return-from-exception, and a period with no new strobe show that out-of-range lines are ignored and that the arming flag clears after each evaluation.

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int SUM_W    = 32,
  parameter int SW_LO    = 4,
  parameter int SW_CNT   = 15,
  parameter int EXT_LO   = 20,
  parameter int EXT_CNT  = 12,
  parameter int LVL_W    = 5,
  parameter int IPL_IN_W = 8,
  parameter int IPL_RST  = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_req_we,
  input  logic [SUM_W-1:0]    sw_req_wdata,
  input  logic [SUM_W-1:0]    ext_irq,
  input  logic                ipl_we,
  input  logic [IPL_IN_W-1:0] ipl_wdata,
  input  logic                check_req,
  input  logic                exc_return,
  output logic                trap_o,
  output logic [SUM_W-1:0]    sw_req_q,
  output logic [LVL_W-1:0]    ipl_q,
  output logic [SUM_W-1:0]    summary_q,
  output logic [LVL_W-1:0]    int_id_q
);

  localparam logic [SUM_W-1:0] SW_MASK  = SUM_W'(((64'd1 << SW_CNT) - 64'd1) << SW_LO);
  localparam logic [SUM_W-1:0] EXT_MASK = SUM_W'(((64'd1 << EXT_CNT) - 64'd1) << EXT_LO);

  logic             armed;
  logic [LVL_W-1:0] cand_lvl;
  logic [SUM_W-1:0] summary_now;
  logic             take;

  always_comb begin
    cand_lvl = '0;
    for (int i = 0; i < SW_CNT; i++)
      if (sw_req_q[SW_LO+i]) cand_lvl = LVL_W'(i + 1);
    for (int i = 0; i < EXT_CNT; i++)
      if (ext_irq[EXT_LO+i]) cand_lvl = LVL_W'(EXT_LO + i);
  end

  assign summary_now = sw_req_q | (ext_irq & EXT_MASK);
  assign take        = armed && (cand_lvl != '0) && (cand_lvl > ipl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req_q  <= '0;
      ipl_q     <= LVL_W'(IPL_RST);
      armed     <= 1'b0;
      trap_o    <= 1'b0;
      summary_q <= '0;
      int_id_q  <= '0;
    end else begin
      if (sw_req_we) sw_req_q <= sw_req_wdata & SW_MASK;
      if (ipl_we)    ipl_q    <= ipl_wdata[LVL_W-1:0];
      armed  <= check_req | exc_return;
      trap_o <= take;
      if (take) begin
        summary_q <= summary_now;
        int_id_q  <= cand_lvl;
      end
    end
  end

  p_ipl_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_we |=> ipl_q == $past(ipl_wdata[LVL_W-1:0]));

  p_trap_above_ipl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_o) |-> int_id_q > $past(ipl_q));

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> ($stable(summary_q) && $stable(int_id_q)));

  p_summary_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> summary_q != '0);

  p_trap_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(armed));

  p_sw_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_we |=> (sw_req_q & ~SW_MASK) == '0);

endmodule

// File: tb/irq_level_resolver_tb_top.sv
module irq_level_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_req_we = 1'b0;
  logic [31:0] sw_req_wdata = '0;
  logic [31:0] ext_irq = '0;
  logic        ipl_we = 1'b0;
  logic [7:0]  ipl_wdata = '0;
  logic        check_req = 1'b0;
  logic        exc_return = 1'b0;
  logic        trap_o;
  logic [31:0] sw_req_q;
  logic [4:0]  ipl_q;
  logic [31:0] summary_q;
  logic [4:0]  int_id_q;

  irq_level_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .sw_req_we(sw_req_we), .sw_req_wdata(sw_req_wdata),
    .ext_irq(ext_irq), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
    .check_req(check_req), .exc_return(exc_return), .trap_o(trap_o),
    .sw_req_q(sw_req_q), .ipl_q(ipl_q), .summary_q(summary_q), .int_id_q(int_id_q));

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          trap;
    logic [31:0] isr;
    logic [4:0]  id;
    string       req;
  } exp_t;

  exp_t  scb[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  logic [31:0] m_isr = '0;
  logic [4:0]  m_id = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares due items, flags any trap with nothing expected
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (scb.size() > 0 && scb[0].due == cyc) begin
        exp_t e;
        e = scb.pop_front();
        chk(trap_o == e.trap, e.req, "trap", {31'd0, trap_o}, {31'd0, e.trap});
        chk(summary_q == e.isr, e.req, "summary", summary_q, e.isr);
        chk(int_id_q == e.id, e.req, "int_id", {27'd0, int_id_q}, {27'd0, e.id});
      end else if (trap_o) begin
        fails++;
        $display("FAIL R8 unexpected trap actual=1 expected=0");
      end
    end
  end

  function automatic void model(input logic [31:0] sw, input logic [31:0] ext,
                                input logic [4:0] ipl, output bit t,
                                output logic [31:0] s, output logic [4:0] l);
    l = 0;
    s = sw;
    for (int k = 4; k <= 18; k++) if (sw[k]) l = 5'(k - 3);
    for (int k = 20; k <= 31; k++) if (ext[k]) begin l = 5'(k); s[k] = 1'b1; end
    t = (l != 0) && (l > ipl);
  endfunction

  task automatic wr_regs(input logic [31:0] sw, input logic [7:0] ipl);
    @(negedge clk);
    sw_req_we = 1; sw_req_wdata = sw; ipl_we = 1; ipl_wdata = ipl;
    @(negedge clk);
    sw_req_we = 0; ipl_we = 0;
  endtask

  // driver: set up inputs, arm, push expected result
  task automatic run_case(input logic [31:0] sw, input logic [31:0] ext,
                          input logic [4:0] ipl, input bit use_rfe, input string req);
    exp_t e;
    bit t; logic [31:0] s; logic [4:0] l;
    ext_irq = ext;
    wr_regs(sw, {3'b000, ipl});
    model(sw & 32'h0007fff0, ext, ipl, t, s, l);
    if (t) begin m_isr = s; m_id = l; end
    e.due = cyc + 2; e.trap = t; e.isr = m_isr; e.id = m_id; e.req = req;
    scb.push_back(e);
    if (use_rfe) exc_return = 1; else check_req = 1;
    @(negedge clk);
    exc_return = 0; check_req = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(trap_o == 0, "R9", "reset trap", {31'd0, trap_o}, 0);
    chk(summary_q == 0, "R9", "reset summary", summary_q, 0);
    chk(int_id_q == 0, "R9", "reset int_id", {27'd0, int_id_q}, 0);
    chk(sw_req_q == 0, "R9", "reset sw_req", sw_req_q, 0);
    chk(ipl_q == 5'd31, "R2", "reset ipl", {27'd0, ipl_q}, 31);

    wr_regs(32'hffff_ffff, 8'he3);
    chk(sw_req_q == 32'h0007fff0, "R1", "sw field", sw_req_q, 32'h0007fff0);
    chk(ipl_q == 5'd3, "R2", "ipl low bits", {27'd0, ipl_q}, 3);

    run_case(32'h0000_0010, 32'h0, 5'd0, 0, "R3 single bit");
    run_case(32'h0004_0020, 32'h0, 5'd0, 0, "R3 highest bit");
    run_case(32'h0004_0000, 32'h0010_0000, 5'd0, 0, "R4 R5 ext override");
    run_case(32'h0, 32'h0200_0000, 5'd25, 0, "R6 R7 equal no trap");
    run_case(32'h0000_0100, 32'h0200_0000, 5'd24, 0, "R6 above");
    run_case(32'h0, 32'h0, 5'd0, 0, "R6 zero level");
    run_case(32'h0, 32'h000f_ffff, 5'd0, 0, "R5 low ext ignored");
    run_case(32'h0000_0040, 32'h8000_0000, 5'd30, 1, "R8 rfe arms");

    // R8: flag cleared, lowering ipl with no new arm gives no trap
    run_case(32'h0000_0080, 32'h0, 5'd10, 0, "R8 blocked");
    wr_regs(32'h0000_0080, 8'd0);
    repeat (5) @(negedge clk);
    chk(trap_o == 0, "R8", "no rearm", {31'd0, trap_o}, 0);
    chk(int_id_q == 5'd31, "R7", "id held", {27'd0, int_id_q}, 31);

    repeat (3) @(negedge clk);
    chk(scb.size() == 0, "R8", "scoreboard drained", scb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule